// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Walker

This block generates the data address for one pointer of a signal-processing load/store path. It keeps a current address plus a lower and an upper bound. On each step pulse it moves the address in one of three ways. In linear mode it adds a signed stride. In circular mode it applies the stride modulo a window bounded by the two bounds, so that a stream buffer can be walked forever. In bit-reversed mode it advances the low index bits in reversed binary order, which gives the shuffle order of a radix-2 FFT.

A single configuration write loads every setting at once and places the pointer on the lower bound. After that, each step pulse produces the next address on the following clock edge. There is no further handshake. The address output comes straight from the pointer register.

Top module: `circ_addr_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the address to 0. It also clears the lower bound, the upper bound and the stride to 0, selects linear mode and sets the FFT field size to 1 bit.
- R2: When `cfg_we` is high at a clock edge, the block loads the bounds, the stride, the mode and the field size. The address becomes `cfg_lo` on that same edge. A configuration write takes priority over a `step` pulse that arrives in the same cycle.
- R3: When neither `cfg_we` nor `step` is high at an edge, the address keeps its value.
- R4: In linear mode (`cfg_mode` = 2'b00), each step adds the stride to the address. The stride is two's complement, and the sum wraps modulo 2^AW.
- R5: In circular mode (`cfg_mode` = 2'b01), let the window length L be hi − lo + 1. A step whose sum goes past the upper bound wraps to lo plus the overshoot, that is lo + (addr − lo + stride − L). A stride of +1 from hi therefore gives lo.
- R6: In circular mode, a step whose sum falls below the lower bound wraps to lo + (addr − lo + stride + L). A stride of −1 from lo therefore gives hi.
- R7: In circular mode, a step that stays inside the window is a plain addition. The result is correct for any stride with magnitude up to L. A stride of exactly ±L returns the same address.
- R8: In bit-reversed mode (`cfg_mode` = 2'b10) with a field of k bits, each step advances the low k address bits by one in reversed binary counting. The carry moves from bit k−1 toward bit 0, and the field wraps to its start after 2^k steps. The stride is ignored in this mode.
- R9: In bit-reversed mode, the address bits at position k and above never change on a step.
- R10: The mode code 2'b11 steps exactly like linear mode.
- R11: The field size is taken from `cfg_fftlog` on a configuration write. A value of 0 is stored as 1, and a value above MAXLOG (default 10) is stored as MAXLOG. The supported FFT sizes are therefore 2 to 1024 points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_lo | input | AW | Lower window bound and start address |
| cfg_hi | input | AW | Upper window bound |
| cfg_stride | input | AW | Signed stride in two's complement |
| cfg_mode | input | 2 | 00 linear, 01 circular, 10 bit-reversed, 11 linear |
| cfg_fftlog | input | LW | Bit-reversed field size in bits (log2 of the FFT size) |
| step | input | 1 | Advance the pointer once |
| addr | output | AW | Current address |

## Verification
The bench targets wrap-around in circular mode from both sides. It uses strides of 1, 3, 4 and the full window length, so a design that clips at the bound instead of carrying the overshoot lands on the wrong address. A design that leaves the window on a full-length stride is caught the same way. Bit-reversed walks run with 3-bit and 10-bit fields, with the field size requested as 0 and as 15, and from start addresses with nonzero upper bits. A carry that runs the wrong way or reaches past bit k−1 then shows up as a wrong order or a corrupted upper address. Separate cases cover a configuration write in the same cycle as a step, a reset in the middle of a walk and a linear walk that wraps below address 0. Each of these exposes a wrong priority or a missing modulo wrap.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    WALK_LIN     = 2'b00,
    WALK_CIRC    = 2'b01,
    WALK_BREV    = 2'b10,
    WALK_LIN_ALT = 2'b11
  } walk_mode_e;

endpackage

// File: rtl/agu_cfg_regs.sv
module agu_cfg_regs
  import agu_pkg::*;
#(
  parameter int AW     = 16,
  parameter int MAXLOG = 10,
  parameter int LW     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_lo,
  input  logic [AW-1:0] cfg_hi,
  input  logic [AW-1:0] cfg_stride,
  input  logic [1:0]    cfg_mode,
  input  logic [LW-1:0] cfg_fftlog,
  output logic [AW-1:0] lo_q,
  output logic [AW-1:0] hi_q,
  output logic [AW-1:0] stride_q,
  output walk_mode_e    mode_q,
  output logic [LW-1:0] klog_q
);

  localparam logic [LW-1:0] KMIN = LW'(1);
  localparam logic [LW-1:0] KMAX = LW'(MAXLOG);

  logic [LW-1:0] klog_clamped;

  // R11: field size limited to 1..MAXLOG
  always_comb begin
    if (cfg_fftlog == '0)       klog_clamped = KMIN;
    else if (cfg_fftlog > KMAX) klog_clamped = KMAX;
    else                        klog_clamped = cfg_fftlog;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q     <= '0;
      hi_q     <= '0;
      stride_q <= '0;
      mode_q   <= WALK_LIN;
      klog_q   <= KMIN;
    end else if (cfg_we) begin
      lo_q     <= cfg_lo;
      hi_q     <= cfg_hi;
      stride_q <= cfg_stride;
      mode_q   <= walk_mode_e'(cfg_mode);
      klog_q   <= klog_clamped;
    end
  end

  a_r11_klog_legal: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_we) |-> (klog_q >= KMIN && klog_q <= KMAX));

endmodule

// File: rtl/agu_step_calc.sv
module agu_step_calc
  import agu_pkg::*;
#(
  parameter int AW     = 16,
  parameter int MAXLOG = 10,
  parameter int LW     = 4
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] stride,
  input  walk_mode_e    mode,
  input  logic [LW-1:0] klog,
  output logic [AW-1:0] nxt,
  output logic [AW-1:0] field_mask,
  output logic          wrap_up,
  output logic          wrap_dn,
  output logic          stride_fits
);

  localparam int CW = AW + 2;

  // Bits that belong to the reversed index field
  for (genvar g = 0; g < AW; g++) begin : g_mask
    if (g < MAXLOG) begin : g_in
      assign field_mask[g] = (LW'(g) < klog);
    end else begin : g_out
      assign field_mask[g] = 1'b0;
    end
  end

  function automatic logic signed [CW-1:0] widen_u(input logic [AW-1:0] v);
    return signed'({2'b00, v});
  endfunction

  function automatic logic signed [CW-1:0] widen_s(input logic [AW-1:0] v);
    return signed'({{2{v[AW-1]}}, v});
  endfunction

  // Reversed-order increment: carry enters at the top field bit and ripples down
  function automatic logic [AW-1:0] brev_bump(input logic [AW-1:0] p,
                                              input logic [AW-1:0] m);
    logic [AW-1:0] r;
    logic          c;
    r = p;
    c = 1'b1;
    for (int i = MAXLOG - 1; i >= 0; i--) begin
      if (m[i]) begin
        r[i] = p[i] ^ c;
        c    = c & p[i];
      end
    end
    return r;
  endfunction

  logic signed [CW-1:0] win_len;
  logic signed [CW-1:0] off_sum;
  logic signed [CW-1:0] off_fix;
  logic signed [CW-1:0] st_w;
  logic signed [CW-1:0] st_mag;
  logic [AW-1:0]        circ_nxt;

  always_comb begin
    win_len     = widen_u(hi) - widen_u(lo) + CW'(1);
    st_w        = widen_s(stride);
    st_mag      = (st_w < 0) ? -st_w : st_w;
    stride_fits = (st_mag <= win_len);
    off_sum     = widen_u(ptr) - widen_u(lo) + st_w;
    wrap_up     = (off_sum >= win_len);
    wrap_dn     = (off_sum < 0);
    if (wrap_up)      off_fix = off_sum - win_len;
    else if (wrap_dn) off_fix = off_sum + win_len;
    else              off_fix = off_sum;
    circ_nxt    = lo + off_fix[AW-1:0];
  end

  always_comb begin
    unique case (mode)
      WALK_CIRC: nxt = circ_nxt;
      WALK_BREV: nxt = brev_bump(ptr, field_mask);
      default:   nxt = ptr + stride;
    endcase
  end

endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
  import agu_pkg::*;
#(
  parameter int AW     = 16,
  parameter int MAXLOG = 10,
  parameter int LW     = $clog2(MAXLOG + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_lo,
  input  logic [AW-1:0] cfg_hi,
  input  logic [AW-1:0] cfg_stride,
  input  logic [1:0]    cfg_mode,
  input  logic [LW-1:0] cfg_fftlog,
  input  logic          step,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] lo_q, hi_q, stride_q, nxt, field_mask;
  walk_mode_e    mode_q;
  logic [LW-1:0] klog_q;
  logic          wrap_up, wrap_dn, stride_fits;
  logic [AW-1:0] ptr_q;

  agu_cfg_regs #(.AW(AW), .MAXLOG(MAXLOG), .LW(LW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_stride(cfg_stride),
    .cfg_mode(cfg_mode), .cfg_fftlog(cfg_fftlog),
    .lo_q(lo_q), .hi_q(hi_q), .stride_q(stride_q),
    .mode_q(mode_q), .klog_q(klog_q)
  );

  agu_step_calc #(.AW(AW), .MAXLOG(MAXLOG), .LW(LW)) u_calc (
    .ptr(ptr_q), .lo(lo_q), .hi(hi_q), .stride(stride_q),
    .mode(mode_q), .klog(klog_q),
    .nxt(nxt), .field_mask(field_mask),
    .wrap_up(wrap_up), .wrap_dn(wrap_dn), .stride_fits(stride_fits)
  );

  // Named events for the checks below
  logic evt_step, evt_circ, evt_circ_up, evt_circ_dn, evt_brev, evt_lin, ptr_in_win;
  assign evt_step    = step && !cfg_we;
  assign evt_circ    = evt_step && (mode_q == WALK_CIRC);
  assign evt_circ_up = evt_circ && wrap_up;
  assign evt_circ_dn = evt_circ && wrap_dn;
  assign evt_brev    = evt_step && (mode_q == WALK_BREV);
  assign evt_lin     = evt_step && (mode_q == WALK_LIN || mode_q == WALK_LIN_ALT);
  assign ptr_in_win  = (ptr_q >= lo_q) && (ptr_q <= hi_q);

  always_ff @(posedge clk) begin
    if (rst)           ptr_q <= '0;
    else if (cfg_we)   ptr_q <= cfg_lo;
    else if (step)     ptr_q <= nxt;
  end

  assign addr = ptr_q;

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (addr == '0));

  a_r2_cfg_load: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (addr == $past(cfg_lo)));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && !step) |=> $stable(addr));

  // R4 and R10: both linear codes add the stride
  a_r4_linear_add: assert property (@(posedge clk) disable iff (rst)
    evt_lin |=> (addr == $past(addr) + $past(stride_q)));

  a_r5_wrap_up_inside: assert property (@(posedge clk) disable iff (rst)
    (evt_circ_up && stride_fits && ptr_in_win) |=>
      (addr >= $past(lo_q) && addr <= $past(hi_q)));

  a_r6_wrap_dn_inside: assert property (@(posedge clk) disable iff (rst)
    (evt_circ_dn && stride_fits && ptr_in_win) |=>
      (addr >= $past(lo_q) && addr <= $past(hi_q)));

  a_r9_brev_upper_kept: assert property (@(posedge clk) disable iff (rst)
    evt_brev |=> ((addr & ~$past(field_mask)) == ($past(addr) & ~$past(field_mask))));

endmodule

// File: tb/circ_addr_gen_bench.sv
module circ_addr_gen_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW   = 16;
  localparam int LW   = 4;
  localparam int AMOD = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_lo = '0, cfg_hi = '0, cfg_stride = '0;
  logic [1:0]    cfg_mode = '0;
  logic [LW-1:0] cfg_fftlog = '0;
  logic          step = 1'b0;
  logic [AW-1:0] addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference model state
  int    m_ptr, m_lo, m_hi, m_stride, m_mode, m_k;
  string tag;
  bit    brev_step;

  always #4 clk = ~clk;

  circ_addr_gen u_circ_addr_gen (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .cfg_stride(cfg_stride), .cfg_mode(cfg_mode), .cfg_fftlog(cfg_fftlog),
    .step(step), .addr(addr)
  );

  function automatic int rev_bits(int v, int k);
    int r = 0;
    for (int i = 0; i < k; i++) if ((v >> i) & 1) r |= 1 << (k - 1 - i);
    return r;
  endfunction

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s addr actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic model_edge(bit r, bit we, int lo, int hi, int st, int md, int fl, bit a);
    brev_step = 0;
    if (r) begin
      m_ptr = 0; m_lo = 0; m_hi = 0; m_stride = 0; m_mode = 0; m_k = 1; tag = "R1";
    end else if (we) begin
      m_lo = lo; m_hi = hi; m_stride = st; m_mode = md;
      m_k = (fl == 0) ? 1 : (fl > 10 ? 10 : fl);
      m_ptr = lo;
      tag = (fl == 0 || fl > 10) ? "R11" : "R2";
    end else if (!a) begin
      tag = "R3";
    end else if (m_mode == 1) begin
      int len = m_hi - m_lo + 1;
      int t = m_ptr - m_lo + m_stride;
      tag = (t >= len) ? "R5" : (t < 0 ? "R6" : "R7");
      t = ((t % len) + len) % len;
      m_ptr = m_lo + t;
    end else if (m_mode == 2) begin
      int fsz = 1 << m_k;
      int low = m_ptr % fsz;
      int nr = (rev_bits(low, m_k) + 1) % fsz;
      m_ptr = (m_ptr - low) + rev_bits(nr, m_k);
      tag = "R8";
      brev_step = 1;
    end else begin
      m_ptr = ((m_ptr + m_stride) % AMOD + AMOD) % AMOD;
      tag = (m_mode == 3) ? "R10" : "R4";
    end
  endtask

  // One clock: drive after the falling edge, model at the rising edge, compare at the next falling edge
  task automatic tick(bit r, bit we, int lo, int hi, int st, int md, int fl, bit a);
    rst = r; cfg_we = we; cfg_lo = AW'(lo); cfg_hi = AW'(hi);
    cfg_stride = AW'(st); cfg_mode = 2'(md); cfg_fftlog = LW'(fl); step = a;
    @(posedge clk);
    model_edge(r, we, lo, hi, st, md, fl, a);
    @(negedge clk);
    check(tag, int'(addr), m_ptr);
    if (brev_step) check("R9", int'(addr) >> m_k, m_ptr >> m_k);
  endtask

  task automatic cfg(int lo, int hi, int st, int md, int fl);
    tick(0, 1, lo, hi, st, md, fl, 0);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick(1, 0, 0, 0, 0, 0, 0, 1);   // R1

    // R4: linear up, then down through address 0
    cfg(16, 0, 3, 0, 1);  steps(5);  idle(2);                   // R3
    cfg(2, 0, -5, 0, 1);  steps(3);

    // R5 / R6 / R7: circular window 100..109
    cfg(100, 109, 1, 1, 1);  steps(12);
    cfg(100, 109, -1, 1, 1); steps(3);
    cfg(100, 109, 4, 1, 1);  steps(8);
    cfg(100, 109, -3, 1, 1); steps(8);
    cfg(100, 109, 10, 1, 1); steps(3);                          // R7 full-length stride
    cfg(100, 109, -10, 1, 1); steps(2);
    idle(2);

    // R8 / R9: bit-reversed walks, stride ignored
    cfg('h5A40, 0, 7, 2, 3);   steps(10);
    cfg('hFC00, 0, 0, 2, 10);  steps(20);
    cfg('h1234, 0, 0, 2, 0);   steps(4);                        // R11 size 0 -> 1
    cfg('h1234, 0, 5, 2, 15);  steps(6);                        // R11 size 15 -> 10

    // R2: write and step in the same cycle, write wins
    cfg(200, 203, 1, 1, 1); steps(2);
    tick(0, 1, 300, 310, 2, 1, 1, 1);
    steps(7);

    // R10: code 11 is linear
    cfg(65530, 0, 7, 3, 1); steps(3);

    // R1: reset in the middle of a walk
    tick(1, 0, 0, 0, 0, 0, 0, 1);
    steps(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule